// File: doc/BRIEF.md
# Instruction Breakpoint Address Match Unit

The block watches the stream of instruction fetch addresses and flags an instruction-breakpoint fault when a fetch hits one of four programmable breakpoint slots. Each slot holds a 32-bit linear address, a local enable, a global enable and a 2-bit access-type code. A slot takes part in fetch matching only when at least one of its enables is set and its access type selects execution. Software loads the slot addresses and one shared control word through a simple address/data/write-enable port.

Every fetch carries a valid strobe and a page-fault flag. The page-fault flag plays no part in matching: a fetch that also faults on translation goes through the same per-slot enable and access-type gating as any other fetch. A disabled slot therefore stays silent even when its stale address equals the faulting fetch. One cycle after a fetch that hits, the block pulses a fault output and latches a 4-bit vector naming every slot that hit. The vector holds until the next hit or until a synchronous clear.

Top module: `bp_match_unit`

## Requirements
- R1: After the active-low asynchronous reset, every address, enable and access-type field is zero, the fault output is 0 and the status vector is 0000; a fetch of address 0 then raises no fault.
- R2: A valid fetch whose address equals the address of an enabled slot with access type 00 drives the fault output to 1 in the following cycle only, for one cycle when the next cycle holds no hit.
- R3: A slot counts as enabled when its local enable, its global enable, or both are 1.
- R4: A slot whose local and global enables are both 0 never contributes to a fault, whether or not the fetch page-fault flag is 1; an enabled matching slot still faults when the page-fault flag is 1.
- R5: A slot whose access type is 01, 10 or 11 never matches a fetch, even when its address equals the fetch address.
- R6: The status vector is registered with the fault; bit n is 1 exactly when slot n hit, so several simultaneous hits set several bits.
- R7: The status vector keeps its value through cycles without a hit and is cleared by the clear input; when a hit and the clear fall in the same cycle the new hit vector is loaded.
- R8: Matching is exact equality on all 32 address bits, and no fault is raised in a cycle after the fetch valid strobe is 0.
- R9: Write addresses 0 to 3 load slot addresses 0 to 3 and address 7 loads the control word, where slot n has local enable at bit 2n, global enable at bit 2n+1 and access type at bits 16+4n+1:16+4n; writes to addresses 4 to 6 change nothing.
- R10: A fetch presented in the same cycle as a write is compared against the slot contents from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register write address |
| wr_data_i | input | 32 | Register write data |
| fetch_valid_i | input | 1 | Fetch address valid |
| fetch_addr_i | input | 32 | Instruction fetch linear address |
| fetch_pf_i | input | 1 | Fetch also takes a page fault |
| clr_i | input | 1 | Synchronous clear of the status vector |
| bp_fault_o | output | 1 | Instruction-breakpoint fault pulse |
| bp_status_o | output | 4 | Slots that caused the last fault |

## Verification
The status clear and a fresh breakpoint hit can land on the same clock edge, and so can a register write and the fetch it would affect. The bench presents a hitting fetch together with a clear while an older vector is latched and expects the new hit vector rather than zero; it also rewrites a slot address in the very cycle a fetch hits the old address and expects the fault from the old value, then a fault on the new one.

// File: rtl/bpm_pkg.sv
`timescale 1ns/1ps
package bpm_pkg;
  localparam int unsigned BP_N      = 4;
  localparam int unsigned ADDR_W    = 32;
  localparam int unsigned REG_AW    = 3;
  localparam int unsigned CTRL_ADDR = 7;
  localparam int unsigned ACC_LSB   = 16;
  localparam int unsigned ACC_STEP  = 4;

  typedef logic [1:0] acc_t;
  localparam acc_t ACC_EXEC = 2'b00;
endpackage

// File: rtl/bpm_regs.sv
`timescale 1ns/1ps
module bpm_regs
  import bpm_pkg::*;
#(
  parameter int unsigned N  = BP_N,
  parameter int unsigned AW = ADDR_W,
  parameter int unsigned RW = REG_AW
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_en_i,
  input  logic [RW-1:0]        wr_addr_i,
  input  logic [AW-1:0]        wr_data_i,
  output logic [N-1:0][AW-1:0] slot_addr_o,
  output logic [N-1:0]         slot_en_o,
  output logic [N-1:0][1:0]    slot_acc_o
);
  localparam logic [RW-1:0] CTRL_SEL = RW'(CTRL_ADDR);

  logic [N-1:0][AW-1:0] addr_q;
  logic [N-1:0]         loc_q, glb_q;
  logic [N-1:0][1:0]    acc_q;

  for (genvar n = 0; n < N; n++) begin : g_slot
    localparam logic [RW-1:0] SEL = RW'(n);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        addr_q[n] <= '0;
        loc_q[n]  <= 1'b0;
        glb_q[n]  <= 1'b0;
        acc_q[n]  <= '0;
      end else if (wr_en_i) begin
        if (wr_addr_i == SEL) addr_q[n] <= wr_data_i;
        if (wr_addr_i == CTRL_SEL) begin
          loc_q[n] <= wr_data_i[2*n];
          glb_q[n] <= wr_data_i[2*n+1];
          acc_q[n] <= wr_data_i[ACC_LSB+ACC_STEP*n +: 2];
        end
      end
    end

    assign slot_addr_o[n] = addr_q[n];
    assign slot_en_o[n]   = loc_q[n] | glb_q[n];
    assign slot_acc_o[n]  = acc_q[n];

    // writes to the unmapped window leave the slot untouched
    AST_UNMAPPED_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i && wr_addr_i != SEL && wr_addr_i != CTRL_SEL)
      |=> ($stable(addr_q[n]) && $stable(slot_en_o[n]) && $stable(acc_q[n]))); // R9
  end
endmodule

// File: rtl/bpm_slot.sv
`timescale 1ns/1ps
module bpm_slot
  import bpm_pkg::*;
#(
  parameter int unsigned AW = ADDR_W
) (
  input  logic          en_i,
  input  logic [1:0]    acc_i,
  input  logic [AW-1:0] addr_i,
  input  logic          fetch_valid_i,
  input  logic [AW-1:0] fetch_addr_i,
  output logic          hit_o
);
  logic exec_armed;

  // gating is applied before the compare result leaves the slot
  assign exec_armed = en_i && (acc_i == ACC_EXEC);
  assign hit_o      = fetch_valid_i && exec_armed && (addr_i == fetch_addr_i);
endmodule

// File: rtl/bpm_report.sv
`timescale 1ns/1ps
module bpm_report #(
  parameter int unsigned N = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] hit_i,
  input  logic         clr_i,
  output logic         fault_o,
  output logic [N-1:0] status_o
);
  logic         fault_q;
  logic [N-1:0] status_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fault_q  <= 1'b0;
      status_q <= '0;
    end else begin
      fault_q <= |hit_i;
      if (|hit_i)     status_q <= hit_i; // new hit wins over clear
      else if (clr_i) status_q <= '0;
    end
  end

  assign fault_o  = fault_q;
  assign status_o = status_q;

  AST_FAULT_NAMES_SLOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> (status_o != '0)); // R6
  AST_CLEAR_EMPTIES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && hit_i == '0) |=> (status_o == '0)); // R7
  AST_STATUS_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && hit_i == '0) |=> ($stable(status_o) && !fault_o)); // R7
  AST_HIT_BEATS_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && hit_i != '0) |=> (fault_o && status_o != '0)); // R7
endmodule

// File: rtl/bp_match_unit.sv
`timescale 1ns/1ps
module bp_match_unit
  import bpm_pkg::*;
#(
  parameter int unsigned N  = BP_N,
  parameter int unsigned AW = ADDR_W,
  parameter int unsigned RW = REG_AW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [RW-1:0] wr_addr_i,
  input  logic [AW-1:0] wr_data_i,
  input  logic          fetch_valid_i,
  input  logic [AW-1:0] fetch_addr_i,
  input  logic          fetch_pf_i,
  input  logic          clr_i,
  output logic          bp_fault_o,
  output logic [N-1:0]  bp_status_o
);
  logic [N-1:0][AW-1:0] slot_addr;
  logic [N-1:0]         slot_en;
  logic [N-1:0][1:0]    slot_acc;
  logic [N-1:0]         hit;

  bpm_regs #(.N(N), .AW(AW), .RW(RW)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_en_i     (wr_en_i),
    .wr_addr_i   (wr_addr_i),
    .wr_data_i   (wr_data_i),
    .slot_addr_o (slot_addr),
    .slot_en_o   (slot_en),
    .slot_acc_o  (slot_acc)
  );

  for (genvar n = 0; n < N; n++) begin : g_cmp
    bpm_slot #(.AW(AW)) u_slot (
      .en_i          (slot_en[n]),
      .acc_i         (slot_acc[n]),
      .addr_i        (slot_addr[n]),
      .fetch_valid_i (fetch_valid_i),
      .fetch_addr_i  (fetch_addr_i),
      .hit_o         (hit[n])
    );

    AST_DISABLED_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (fetch_valid_i && !slot_en[n]) |=> !bp_status_o[n] || !bp_fault_o); // R4
    AST_DATA_SLOT_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (fetch_valid_i && slot_acc[n] != ACC_EXEC) |=> !bp_status_o[n] || !bp_fault_o); // R5
  end

  bpm_report #(.N(N)) u_report (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .hit_i    (hit),
    .clr_i    (clr_i),
    .fault_o  (bp_fault_o),
    .status_o (bp_status_o)
  );

  AST_PF_NO_BYPASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fetch_valid_i && fetch_pf_i && slot_en == '0) |=> !bp_fault_o); // R4
  AST_IDLE_NO_FAULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fetch_valid_i |=> !bp_fault_o); // R8
endmodule

// File: tb/bp_match_unit_bench.sv
`timescale 1ns/1ps
module bp_match_unit_bench;
  localparam logic [31:0] A0 = 32'h0000_1000;
  localparam logic [31:0] A1 = 32'h0000_2004;
  localparam logic [31:0] A2 = 32'hDEAD_BEEF;
  localparam logic [31:0] A3 = 32'h8000_0000;
  localparam logic [31:0] B0 = 32'h0000_3000;

  typedef struct packed {
    logic [3:0]  l;
    logic [3:0]  g;
    logic [7:0]  acc;   // {acc3,acc2,acc1,acc0}
    logic [31:0] a;
    logic        pf;
    logic        ef;
    logic [3:0]  es;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t TBL [NV] = '{
    '{4'b0001, 4'b0000, 8'h00, A0, 1'b0, 1'b1, 4'b0001}, // R2 R3 local only
    '{4'b0000, 4'b0100, 8'h00, A2, 1'b0, 1'b1, 4'b0100}, // R3 global only
    '{4'b0000, 4'b0000, 8'h00, A1, 1'b0, 1'b0, 4'b0000}, // R4 all off
    '{4'b0000, 4'b0000, 8'h00, A1, 1'b1, 1'b0, 4'b0000}, // R4 all off, page fault
    '{4'b0001, 4'b0000, 8'h00, A1, 1'b1, 1'b0, 4'b0000}, // R4 disabled slot1 hit with pf
    '{4'b0001, 4'b0000, 8'h00, A0, 1'b1, 1'b1, 4'b0001}, // R4 enabled still faults with pf
    '{4'b0000, 4'b0010, 8'h04, A1, 1'b0, 1'b0, 4'b0000}, // R5 acc 01
    '{4'b1000, 4'b0000, 8'hC0, A3, 1'b0, 1'b0, 4'b0000}, // R5 acc 11
    '{4'b0000, 4'b1000, 8'h80, A3, 1'b1, 1'b0, 4'b0000}, // R5 acc 10
    '{4'b1111, 4'b1111, 8'h00, A0 ^ 32'h1, 1'b0, 1'b0, 4'b0000}, // R8 one bit off
    '{4'b1111, 4'b0000, 8'h00, A3, 1'b0, 1'b1, 4'b1000}, // R8 msb address
    '{4'b0010, 4'b0010, 8'h00, A1, 1'b0, 1'b1, 4'b0010}  // R3 both enables
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [2:0]  wr_addr_i = '0;
  logic [31:0] wr_data_i = '0;
  logic        fetch_valid_i = 1'b0;
  logic [31:0] fetch_addr_i = '0;
  logic        fetch_pf_i = 1'b0;
  logic        clr_i = 1'b0;
  logic        bp_fault_o;
  logic [3:0]  bp_status_o;

  int checks = 0;
  int fails  = 0;

  always #4 clk_i = ~clk_i; // 125 MHz

  bp_match_unit u_bp_match_unit (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .fetch_valid_i, .fetch_addr_i, .fetch_pf_i, .clr_i,
    .bp_fault_o, .bp_status_o
  );

  function automatic logic [31:0] ctl(input logic [3:0] l, input logic [3:0] g,
                                      input logic [7:0] acc);
    logic [31:0] w = '0;
    for (int n = 0; n < 4; n++) begin
      w[2*n]          = l[n];
      w[2*n+1]        = g[n];
      w[16+4*n +: 2]  = acc[2*n +: 2];
    end
    return w;
  endfunction

  task automatic chk(input string req, input logic ef, input logic [3:0] es);
    checks++;
    if (bp_fault_o !== ef || bp_status_o !== es) begin
      fails++;
      $display("FAIL %s: fault=%b status=%b expected fault=%b status=%b",
               req, bp_fault_o, bp_status_o, ef, es);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  // fetch one cycle; outputs are valid at the following negedge
  task automatic fetch(input logic [31:0] a, input logic pf, input logic clr);
    @(negedge clk_i);
    fetch_valid_i = 1'b1; fetch_addr_i = a; fetch_pf_i = pf; clr_i = clr;
    @(negedge clk_i);
    fetch_valid_i = 1'b0; fetch_pf_i = 1'b0; clr_i = 1'b0;
  endtask

  task automatic clear();
    @(negedge clk_i);
    clr_i = 1'b1;
    @(negedge clk_i);
    clr_i = 1'b0;
  endtask

  initial begin
    #800000;
    fails++;
    $display("FAIL watchdog: fault=%b status=%b expected completion", bp_fault_o, bp_status_o);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk("R1 in reset", 1'b0, 4'b0000);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 after reset", 1'b0, 4'b0000);
    fetch(32'h0, 1'b0, 1'b0);
    chk("R1 zero fetch", 1'b0, 4'b0000);

    wr(3'd0, A0); wr(3'd1, A1); wr(3'd2, A2); wr(3'd3, A3);

    for (int i = 0; i < NV; i++) begin
      wr(3'd7, ctl(TBL[i].l, TBL[i].g, TBL[i].acc));
      clear();
      fetch(TBL[i].a, TBL[i].pf, 1'b0);
      chk($sformatf("R2/R3/R4/R5/R8 vector %0d", i), TBL[i].ef, TBL[i].es);
    end

    // R2 pulse width and R7 hold
    wr(3'd7, ctl(4'b0001, 4'b0000, 8'h00));
    clear();
    fetch(A0, 1'b0, 1'b0);
    chk("R2 pulse high", 1'b1, 4'b0001);
    @(negedge clk_i);
    chk("R2 pulse one cycle, R7 hold", 1'b0, 4'b0001);
    fetch(A1, 1'b0, 1'b0);
    chk("R7 hold over miss", 1'b0, 4'b0001);
    clear();
    chk("R7 clear", 1'b0, 4'b0000);

    // R7 hit and clear in the same cycle
    fetch(A0, 1'b0, 1'b0);
    wr(3'd7, ctl(4'b0100, 4'b0000, 8'h00));
    fetch(A2, 1'b0, 1'b1);
    chk("R7 hit beats clear", 1'b1, 4'b0100);

    // R8 valid low
    wr(3'd7, ctl(4'b1111, 4'b0000, 8'h00));
    clear();
    @(negedge clk_i);
    fetch_addr_i = A0;
    @(negedge clk_i);
    chk("R8 valid low", 1'b0, 4'b0000);

    // R6 two slots on one address
    wr(3'd1, A0);
    fetch(A0, 1'b0, 1'b0);
    chk("R6 multi hit", 1'b1, 4'b0011);

    // R9 unmapped writes: no enable change, no address change
    wr(3'd7, 32'h0);
    wr(3'd4, ctl(4'b1111, 4'b1111, 8'h00));
    wr(3'd5, A3);
    wr(3'd6, ctl(4'b1111, 4'b1111, 8'h00));
    clear();
    fetch(A0, 1'b0, 1'b0);
    chk("R9 unmapped leaves enables", 1'b0, 4'b0000);
    wr(3'd7, ctl(4'b0001, 4'b0000, 8'h00));
    fetch(A0, 1'b0, 1'b0);
    chk("R9 unmapped leaves slot0 address", 1'b1, 4'b0001);

    // R10 write and fetch in the same cycle
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_addr_i = 3'd0; wr_data_i = B0;
    fetch_valid_i = 1'b1; fetch_addr_i = A0;
    @(negedge clk_i);
    wr_en_i = 1'b0; fetch_valid_i = 1'b0;
    chk("R10 old address compared", 1'b1, 4'b0001);
    fetch(B0, 1'b0, 1'b0);
    chk("R10 new address live", 1'b1, 4'b0001);
    clear();
    fetch(A0, 1'b0, 1'b0);
    chk("R10 old address gone", 1'b0, 4'b0000);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule